// File: doc/BRIEF.md
# Packed R11G11B10 Small-Float Colour Codec

This block converts between a 32-bit packed colour word that holds three unsigned small floats and the wider floating-point formats used in a pixel pipeline. Red sits in bits [10:0], green in bits [21:11] and blue in bits [31:22]. All three fields use a 5-bit exponent. The two 11-bit fields carry a 6-bit mantissa, and the 10-bit blue field carries a 5-bit mantissa.

The unpack path takes one packed word. It realigns each field into half-precision layout, because the exponent width is the same. It then widens each half value to IEEE single precision. Alpha is always 1.0. The pack path takes three half-precision channels and builds the packed word from the upper bits of each. It drops the sign and truncates the low mantissa bits; it does not round. Converting single precision to half precision is done by a separate block.

Both paths are combinational. The parameter `REG_OUT` adds one output register stage with an asynchronous active-low reset.

Top module: `rgb_minifloat_codec`

## Requirements
- R1: A red field with exponent e in 1..30 and mantissa m (6 bits) unpacks to a single with sign 0, biased exponent e+112 in bits [30:23], m in bits [22:17] and zeros below.
- R2: The green field is taken from word bits [21:11] and converts by the same rule as red.
- R3: The blue field is taken from word bits [31:22]. Its 5-bit mantissa lands in single bits [22:18].
- R4: A field whose exponent is all ones unpacks to single exponent 0xFF with the field mantissa kept. Infinity therefore stays infinity, and NaN stays NaN.
- R5: A field with exponent 0 unpacks to +0.0 when its mantissa is 0. Otherwise it unpacks to the normalised single equal to (half mantissa) × 2^-24. The half mantissa is the field mantissa shifted left by 4 for red and green, and by 5 for blue.
- R6: The alpha output is always 0x3F800000, which is 1.0.
- R7: Bit 31 of every unpacked colour channel is 0.
- R8: The packed word is {blue_half[14:5], green_half[14:4], red_half[14:4]}. The half sign bit and the lower mantissa bits have no effect.
- R9: On pack, half infinity 0x7C00 gives a field with all-ones exponent and zero mantissa. A half NaN whose set mantissa bits all lie in the truncated part becomes that infinity code.
- R10: Unpacking any word, converting each channel to half exactly, and packing again returns the same word for every red and green value (2^11 each) and every blue value (2^10).
- R11: With `REG_OUT`=1, results appear one clock after the inputs, and all outputs are 0 while reset is held. With `REG_OUT`=0, the outputs are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| unpk_word | input | 32 | Packed word to unpack |
| unpk_red | output | 32 | Red as single precision |
| unpk_grn | output | 32 | Green as single precision |
| unpk_blu | output | 32 | Blue as single precision |
| unpk_alf | output | 32 | Alpha, constant 1.0 |
| pk_red_h | input | 16 | Red half value to pack |
| pk_grn_h | input | 16 | Green half value to pack |
| pk_blu_h | input | 16 | Blue half value to pack |
| pk_word | output | 32 | Packed result |

## Verification
With the default output stage, each unpacked channel and the packed word are due exactly one clock edge after their inputs change. The bench changes inputs on a falling edge and reads the outputs on the next falling edge, which is one full cycle after capture and away from the rising edge. The exhaustive round trip chains two such steps: unpack, then repack from halves computed in the bench. The reset check reads the outputs while reset is still held, before the first capture.

// File: rtl/rgb_minifloat_codec.sv
module rgb_minifloat_codec #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] unpk_word,
  output logic [31:0] unpk_red,
  output logic [31:0] unpk_grn,
  output logic [31:0] unpk_blu,
  output logic [31:0] unpk_alf,
  input  logic [15:0] pk_red_h,
  input  logic [15:0] pk_grn_h,
  input  logic [15:0] pk_blu_h,
  output logic [31:0] pk_word
);
  localparam logic [15:0] HALF_ONE = 16'h3C00;

  function automatic logic [31:0] widen(input logic [15:0] h);
    logic [4:0]  e;
    logic [9:0]  m;
    logic [3:0]  p;
    logic [32:0] sh;
    e = h[14:10];
    m = h[9:0];
    p = 4'd0;
    for (int i = 0; i < 10; i++)
      if (m[i]) p = 4'(i);
    sh = 33'(m) << (5'd23 - 5'(p));
    if (e == 5'h1F)
      widen = {h[15], 8'hFF, m, 13'd0};
    else if (e != 5'd0)
      widen = {h[15], 8'(e) + 8'd112, m, 13'd0};
    else if (m == 10'd0)
      widen = {h[15], 31'd0};
    else
      widen = {h[15], 8'(p) + 8'd103, sh[22:0]};
  endfunction

  logic [15:0] r_h, g_h, b_h;
  logic [31:0] r_f, g_f, b_f, a_f, pk_c;

  assign r_h = {1'b0, unpk_word[10:0], 4'd0};
  assign g_h = {1'b0, unpk_word[21:11], 4'd0};
  assign b_h = {1'b0, unpk_word[31:22], 5'd0};

  assign r_f = widen(r_h);
  assign g_f = widen(g_h);
  assign b_f = widen(b_h);
  assign a_f = widen(HALF_ONE);

  assign pk_c = {pk_blu_h[14:5], pk_grn_h[14:4], pk_red_h[14:4]};

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          unpk_red <= '0;
          unpk_grn <= '0;
          unpk_blu <= '0;
          unpk_alf <= '0;
          pk_word  <= '0;
        end else begin
          unpk_red <= r_f;
          unpk_grn <= g_f;
          unpk_blu <= b_f;
          unpk_alf <= a_f;
          pk_word  <= pk_c;
        end
      end
    end else begin : g_comb
      assign unpk_red = r_f;
      assign unpk_grn = g_f;
      assign unpk_blu = b_f;
      assign unpk_alf = a_f;
      assign pk_word  = pk_c;
    end
  endgenerate
endmodule

// File: rtl/rgb_minifloat_codec_chk.sv
module rgb_minifloat_codec_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] unpk_word,
  input logic [31:0] unpk_red,
  input logic [31:0] unpk_grn,
  input logic [31:0] unpk_blu,
  input logic [31:0] unpk_alf,
  input logic [15:0] pk_red_h,
  input logic [15:0] pk_grn_h,
  input logic [15:0] pk_blu_h,
  input logic [31:0] pk_word
);
  logic [31:0] w_d;
  logic [15:0] hr_d, hg_d, hb_d;
  logic        seen;

  generate
    if (REG_OUT) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          w_d <= '0; hr_d <= '0; hg_d <= '0; hb_d <= '0; seen <= 1'b0;
        end else begin
          w_d <= unpk_word; hr_d <= pk_red_h; hg_d <= pk_grn_h;
          hb_d <= pk_blu_h; seen <= 1'b1;
        end
      end
    end else begin : g_now
      assign w_d  = unpk_word;
      assign hr_d = pk_red_h;
      assign hg_d = pk_grn_h;
      assign hb_d = pk_blu_h;
      assign seen = 1'b1;
    end
  endgenerate

  // R7
  sign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (!unpk_red[31] && !unpk_grn[31] && !unpk_blu[31]));

  // R6
  alpha_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> unpk_alf == 32'h3F800000);

  // R1
  red_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && w_d[10:6] != 5'd0 && w_d[10:6] != 5'h1F) |->
      (unpk_red[30:23] == 8'(w_d[10:6]) + 8'd112 && unpk_red[22:17] == w_d[5:0]
       && unpk_red[16:0] == 17'd0));

  // R4
  blue_special_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && w_d[31:27] == 5'h1F) |->
      (unpk_blu[30:23] == 8'hFF && unpk_blu[22:18] == w_d[26:22]));

  // R5
  green_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && w_d[21:11] == 11'd0) |-> unpk_grn == 32'd0);

  // R8
  pack_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (pk_word[10:0] == hr_d[14:4] && pk_word[21:11] == hg_d[14:4]
              && pk_word[31:22] == hb_d[14:5]));
endmodule

bind rgb_minifloat_codec rgb_minifloat_codec_chk #(.REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/test_rgb_minifloat_codec.sv
`timescale 1ns/1ps
module test_rgb_minifloat_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] unpk_word = '0;
  logic [31:0] unpk_red, unpk_grn, unpk_blu, unpk_alf, pk_word;
  logic [15:0] pk_red_h = '0, pk_grn_h = '0, pk_blu_h = '0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rgb_minifloat_codec #(.REG_OUT(1'b1)) i_rgb_minifloat_codec (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [15:0] to_half(input logic [31:0] f);
    logic [7:0] e;
    logic [23:0] sig;
    e = f[30:23];
    sig = {1'b1, f[22:0]};
    if (e == 8'hFF) return {f[31], 5'h1F, f[22:13]};
    if (e == 8'd0) return {f[31], 15'd0};
    if (e >= 8'd113) return {f[31], 5'(e - 8'd112), f[22:13]};
    return {f[31], 5'd0, 10'(sig >> (8'd126 - e))};
  endfunction

  task automatic t_reset();
    chk("R11 reset red", unpk_red, 32'd0);
    chk("R11 reset alpha", unpk_alf, 32'd0);
    chk("R11 reset pack", pk_word, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    unpk_word = 32'h0000_03C0;
    chk("R11 no change before edge", unpk_red, 32'd0);
    step();
    chk("R11 one-cycle latency", unpk_red, 32'h3F800000);
  endtask

  task automatic t_normals();
    unpk_word = {10'h1E0, 11'h7BF, 11'h7BF};
    step();
    chk("R1 red max normal", unpk_red, 32'h477E0000);
    chk("R2 green max normal", unpk_grn, 32'h477E0000);
    chk("R3 blue 1.0", unpk_blu, 32'h3F800000);
    chk("R6 alpha", unpk_alf, 32'h3F800000);
    unpk_word = {10'h1FF, 11'h3C0, 11'h041};
    step();
    chk("R3 blue mantissa", unpk_blu, 32'h3FFC0000);
    chk("R2 green 1.0", unpk_grn, 32'h3F800000);
    chk("R1 red min normal", unpk_red, 32'h38820000);
  endtask

  task automatic t_special();
    unpk_word = {10'h3E1, 11'h7C0, 11'h7C1};
    step();
    chk("R4 blue NaN kept", unpk_blu, 32'h7F840000);
    chk("R4 green infinity", unpk_grn, 32'h7F800000);
    chk("R4 red NaN kept", unpk_red, 32'h7F820000);
    chk("R7 sign clear", {31'd0, unpk_red[31] | unpk_grn[31] | unpk_blu[31]}, 32'd0);
  endtask

  task automatic t_subnormal();
    unpk_word = {10'h001, 11'h000, 11'h001};
    step();
    chk("R5 red smallest subnormal", unpk_red, 32'h35800000);
    chk("R5 green zero", unpk_grn, 32'h00000000);
    chk("R5 blue smallest subnormal", unpk_blu, 32'h36000000);
    unpk_word = {10'h01F, 11'h03F, 11'h020};
    step();
    chk("R5 red top subnormal", unpk_red, 32'h38000000);
    chk("R5 green largest subnormal", unpk_grn, 32'h387C0000);
    chk("R5 blue largest subnormal", unpk_blu, 32'h38780000);
  endtask

  task automatic t_pack();
    pk_red_h = 16'h3C0F; pk_grn_h = 16'hBC00; pk_blu_h = 16'h3C1F;
    step();
    chk("R8 pack truncate and drop sign", pk_word, {10'h1E0, 11'h3C0, 11'h3C0});
    pk_red_h = 16'h7BFF; pk_grn_h = 16'h0010; pk_blu_h = 16'h8020;
    step();
    chk("R8 pack max and subnormal", pk_word, {10'h001, 11'h001, 11'h7BF});
  endtask

  task automatic t_pack_special();
    pk_red_h = 16'h7C00; pk_grn_h = 16'h7C01; pk_blu_h = 16'h7C10;
    step();
    chk("R9 inf and low-bit NaN", pk_word, {10'h3E0, 11'h7C0, 11'h7C0});
    pk_red_h = 16'h7C10; pk_grn_h = 16'hFE00; pk_blu_h = 16'h7C20;
    step();
    chk("R9 NaN kept", pk_word, {10'h3E1, 11'h7E0, 11'h7C1});
  endtask

  task automatic t_roundtrip();
    int errs = 0;
    for (int i = 0; i < 2048; i++) begin
      logic [31:0] w;
      w = {10'(i), 11'(i), 11'(i)};
      unpk_word = w;
      step();
      pk_red_h = to_half(unpk_red);
      pk_grn_h = to_half(unpk_grn);
      pk_blu_h = to_half(unpk_blu);
      step();
      if (pk_word !== w) begin
        errs++;
        chk("R10 round trip", pk_word, w);
      end
    end
    chk("R10 round trip exhaustive mismatches", 32'(errs), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_normals();
    t_special();
    t_subnormal();
    t_pack();
    t_pack_special();
    t_roundtrip();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule